// File: doc/BRIEF.md
# UART receiver idle timeout detector

This block runs alongside a UART receiver and reports when the receive line has stayed silent for too long after a character. The receiver supplies one strobe per bit period, a pulse when a character has been fully received, and a pulse when a new start bit is seen. After each completed character the block counts bit periods. If no start bit arrives before the count passes a programmed limit, it raises a sticky timeout flag. An interrupt request follows that flag when interrupts are enabled.

The limit is a 24-bit value measured in bit periods. It is loaded through a one-cycle write strobe with a data word, and it may be changed while a count is running. If the new limit is at or below the count already reached, the flag is raised at once. Software drops the flag with a clear strobe. A master enable holds the whole function idle. The asynchronous active-low reset is released through a two-stage synchronizer inside the block.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset release, tmo_flag and irq are 0, and the programmed limit equals parameter RESET_LIMIT (default 0).
- R2: With enable high and limit N, the flag sets in the cycle after the (N+1)-th bit_tick that follows a char_done pulse, provided no start_det came in between. After only N ticks the flag is still 0.
- R3: A start_det pulse clears the count and stops counting, so no later tick sets the flag until the next char_done.
- R4: With a limit of 0, the first bit_tick after char_done sets the flag.
- R5: A write of a value less than or equal to the current count, while a count is running, sets the flag in the cycle after the write strobe.
- R6: A write of a value greater than the current count does not set the flag. The timeout then happens when the count reaches the new value.
- R7: While tmo_en is 0 the count is held cleared and the flag never sets, whatever ticks or character pulses arrive.
- R8: irq is 1 exactly when tmo_flag is 1 and irq_en is 1. It is 0 whenever irq_en is 0.
- R9: The flag stays set until flag_clr. A flag_clr alone clears it in the next cycle. If a set condition occurs in the same cycle as flag_clr, the set wins.
- R10: Once the flag has fired, counting stops. Further bit_ticks and limit writes do not set it again until another char_done.
- R11: A char_done that arrives while a count is running restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_en | input | 1 | Enables the timeout function |
| irq_en | input | 1 | Passes the flag to irq |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| char_done | input | 1 | Pulse at the end of a received character |
| start_det | input | 1 | Pulse when a start bit is detected |
| cfg_we | input | 1 | Write strobe for the limit |
| cfg_wdata | input | CNT_W | Limit value in bit periods |
| flag_clr | input | 1 | Clears the timeout flag |
| tmo_flag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Interrupt request |

## Verification
The table-driven part sweeps several limits, including 0, 1, 3, 7 and 20. For each limit it gives either exactly the limit in ticks or one tick more, so that an off-by-one in the compare shows up on one side or the other. Directed cases then separate the paths that look alike at the flag. These are a start bit that cancels a count, a restart by a second character, and rewrites above and below the running count. They also include the set-versus-clear collision, the silence after a fire, and the disabled state.

// File: rtl/rx_idle_timeout_pkg.sv
package rx_idle_timeout_pkg;
  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_EXPIRE  = 2'd1,
    EV_REPROG  = 2'd2
  } tmo_event_e;
endpackage

// File: rtl/rto_limit_reg.sv
module rto_limit_reg #(
  parameter int W = 24,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] limit
);
  logic [W-1:0] limit_q, limit_d;

  always_comb begin
    limit_d = limit_q;
    if (we) limit_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) limit_q <= RST_VAL;
    else        limit_q <= limit_d;
  end

  assign limit = limit_q;
endmodule

// File: rtl/rto_compare.sv
module rto_compare
  import rx_idle_timeout_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         en,
  input  logic         armed,
  input  logic         bit_tick,
  input  logic         start_det,
  input  logic         char_done,
  input  logic [W-1:0] count,
  input  logic [W-1:0] limit,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output tmo_event_e   event_o,
  output logic         fire
);
  logic live;
  logic expire_hit;
  logic reprog_hit;

  always_comb begin
    live       = en && armed && !start_det && !char_done;
    // a tick that lifts the elapsed bit count above the active limit
    expire_hit = live && bit_tick && (count >= (we ? wdata : limit));
    reprog_hit = live && we && (wdata <= count);
    if (reprog_hit)      event_o = EV_REPROG;
    else if (expire_hit) event_o = EV_EXPIRE;
    else                 event_o = EV_NONE;
    fire = (event_o != EV_NONE);
  end
endmodule

// File: rtl/rto_bit_counter.sv
module rto_bit_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         bit_tick,
  input  logic         start_det,
  input  logic         char_done,
  input  logic         fire,
  output logic [W-1:0] count,
  output logic         armed
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         arm_q, arm_d;
  logic         cnt_ce;

  always_comb begin
    cnt_d  = cnt_q;
    arm_d  = arm_q;
    cnt_ce = 1'b0;
    if (!en) begin
      cnt_d = '0; arm_d = 1'b0; cnt_ce = 1'b1;
    end else if (start_det) begin
      cnt_d = '0; arm_d = 1'b0; cnt_ce = 1'b1;
    end else if (char_done) begin
      cnt_d = '0; arm_d = 1'b1; cnt_ce = 1'b1;
    end else if (arm_q) begin
      if (bit_tick && cnt_q != CNT_MAX) begin
        cnt_d  = cnt_q + 1'b1;
        cnt_ce = 1'b1;
      end
      if (fire) begin
        arm_d  = 1'b0;
        cnt_ce = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
      arm_q <= arm_d;
    end
  end

  assign count = cnt_q;
  assign armed = arm_q;
endmodule

// File: rtl/rto_flag_ctrl.sv
module rto_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign irq  = flag_q & irq_en;
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
  import rx_idle_timeout_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter logic [CNT_W-1:0] RESET_LIMIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmo_en,
  input  logic             irq_en,
  input  logic             bit_tick,
  input  logic             char_done,
  input  logic             start_det,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             flag_clr,
  output logic             tmo_flag,
  output logic             irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] count;
  logic             armed;
  logic             fire;
  tmo_event_e       evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rto_limit_reg #(.W(CNT_W), .RST_VAL(RESET_LIMIT)) u_limit (
    .clk(clk), .rst_n(rst_int_n), .we(cfg_we), .wdata(cfg_wdata), .limit(limit)
  );

  rto_compare #(.W(CNT_W)) u_cmp (
    .en(tmo_en), .armed(armed), .bit_tick(bit_tick), .start_det(start_det),
    .char_done(char_done), .count(count), .limit(limit), .we(cfg_we),
    .wdata(cfg_wdata), .event_o(evt), .fire(fire)
  );

  rto_bit_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .en(tmo_en), .bit_tick(bit_tick),
    .start_det(start_det), .char_done(char_done), .fire(fire),
    .count(count), .armed(armed)
  );

  rto_flag_ctrl u_flag (
    .clk(clk), .rst_n(rst_int_n), .set(fire), .clr(flag_clr),
    .irq_en(irq_en), .flag(tmo_flag), .irq(irq)
  );
endmodule

// File: rtl/rx_idle_timeout_checker.sv
module rx_idle_timeout_checker (
  input logic clk,
  input logic rst_n,
  input logic tmo_en,
  input logic irq_en,
  input logic start_det,
  input logic flag_clr,
  input logic tmo_flag,
  input logic irq
);
  a_r7_no_set_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_en |=> !$rose(tmo_flag));
  a_r3_start_blocks_set: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !$rose(tmo_flag));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !flag_clr) |=> tmo_flag);
  a_r9_clear_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !tmo_en) |=> !tmo_flag);
  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tmo_flag);
endmodule

bind rx_idle_timeout rx_idle_timeout_checker u_chk (
  .clk(clk), .rst_n(rst_int_n), .tmo_en(tmo_en), .irq_en(irq_en),
  .start_det(start_det), .flag_clr(flag_clr), .tmo_flag(tmo_flag), .irq(irq)
);

// File: tb/rx_idle_timeout_test.sv
module rx_idle_timeout_test;
  localparam int W = 24;
  localparam int NV = 8;
  // each vector: {limit, ticks after char_done}; expect flag = ticks > limit
  localparam int VEC [NV][2] = '{
    '{3, 3}, '{3, 4}, '{0, 1}, '{0, 0},
    '{7, 8}, '{7, 7}, '{1, 2}, '{20, 21}
  };

  logic clk = 1'b0;
  logic rst_n, tmo_en, irq_en, bit_tick, char_done, start_det, cfg_we, flag_clr;
  logic [W-1:0] cfg_wdata;
  logic tmo_flag, irq;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_idle_timeout #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tmo_en(tmo_en), .irq_en(irq_en),
    .bit_tick(bit_tick), .char_done(char_done), .start_det(start_det),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .flag_clr(flag_clr),
    .tmo_flag(tmo_flag), .irq(irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
    end
  endtask
  task automatic chr();
    @(negedge clk) char_done = 1'b1;
    @(negedge clk) char_done = 1'b0;
  endtask
  task automatic wr(input int v);
    @(negedge clk) begin cfg_we = 1'b1; cfg_wdata = W'(v); end
    @(negedge clk) cfg_we = 1'b0;
  endtask
  task automatic clr();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; tmo_en = 1'b0; irq_en = 1'b0; bit_tick = 1'b0;
    char_done = 1'b0; start_det = 1'b0; cfg_we = 1'b0; flag_clr = 1'b0;
    cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 flag", tmo_flag, 1'b0);
    check("R1 irq", irq, 1'b0);
    tmo_en = 1'b1;
    // R1: reset limit is 0, so one tick after a character fires
    chr(); ticks(1);
    check("R1 reset limit", tmo_flag, 1'b1);
    clr();
    check("R9 clear", tmo_flag, 1'b0);

    // R2 / R4 table walk
    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][0]); clr(); chr(); ticks(VEC[v][1]);
      check(VEC[v][0] == 0 ? "R4 zero limit" : "R2 expiry",
            tmo_flag, VEC[v][1] > VEC[v][0]);
      clr();
    end

    // R3 start bit cancels count
    wr(2); chr(); ticks(2);
    @(negedge clk) start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
    ticks(5);
    check("R3 start cancels", tmo_flag, 1'b0);

    // R11 restart by second character
    wr(4); chr(); ticks(3); chr(); ticks(3);
    check("R11 restart", tmo_flag, 1'b0);
    ticks(2);
    check("R11 expiry after restart", tmo_flag, 1'b1);
    clr();

    // R5 rewrite at or below count
    wr(10); chr(); ticks(5); wr(5);
    check("R5 immediate set", tmo_flag, 1'b1);
    clr();

    // R6 rewrite above count
    wr(2); chr(); ticks(2); wr(6); ticks(4);
    check("R6 no early set", tmo_flag, 1'b0);
    ticks(1);
    check("R6 new limit", tmo_flag, 1'b1);

    // R8 irq gating
    check("R8 irq masked", irq, 1'b0);
    @(negedge clk) irq_en = 1'b1;
    @(negedge clk);
    check("R8 irq on", irq, 1'b1);
    clr();
    check("R8 irq drops", irq, 1'b0);

    // R10 silence after fire
    wr(1); chr(); ticks(2);
    check("R10 fired", tmo_flag, 1'b1);
    clr(); ticks(5); wr(0);
    check("R10 no refire", tmo_flag, 1'b0);

    // R9 set wins over clear
    wr(0); chr();
    @(negedge clk) begin bit_tick = 1'b1; flag_clr = 1'b1; end
    @(negedge clk) begin bit_tick = 1'b0; flag_clr = 1'b0; end
    check("R9 set wins", tmo_flag, 1'b1);
    @(negedge clk);
    check("R9 sticky", tmo_flag, 1'b1);
    clr();

    // R7 disabled
    @(negedge clk) tmo_en = 1'b0;
    wr(0); chr(); ticks(10);
    check("R7 disabled", tmo_flag, 1'b0);
    @(negedge clk) tmo_en = 1'b1;
    ticks(3);
    check("R7 count held clear", tmo_flag, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule